// File: doc/BRIEF.md
# E1 Transmit Diagnostic Pattern Selector

This block sits in front of the line encoder of a multi-channel E1 transmitter. Each channel either forwards the user's transmit data or replaces it with a test pattern. The user data arrives either as a positive/negative rail pair or as one data rail. The test patterns are a steady all-ones (marks) signal, an all-ones signal raised automatically when the channel's receiver reports loss of signal, or a QRSS pseudo-random sequence. A channel that sends any test pattern switches to single-rail operation. The block then produces the AMI marks itself, alternating between the positive and negative encoder rails.

The block also drives the receive positive data seen on each channel's digital or dual loopback path. When manual all ones is on, that path keeps showing the user's transmit data. When the automatic all ones or QRSS pattern is on, the path shows the test bit that goes to the line. Without loopback it forwards the recovered receive data. All outputs are registered, and mode changes act on the next clock edge. Each channel keeps its own AMI polarity and its own pattern generator.

Top module: `e1_tx_diag_sel`

## Requirements
- R1: While reset is held, and until the first non-idle input after it, every output is 0. The mark polarity of each channel starts on the positive rail. The QRSS register of each channel starts at a nonzero seed (default 1).
- R2: With `force_ones` set on a channel, each bit period carries exactly one mark. `enc_single` is 1. Consecutive marks alternate positive, negative, positive. The rail inputs are ignored.
- R3: With `auto_ones_en` set, `rlos` set and `force_ones` clear, the channel sends AMI all ones exactly as in R2.
- R4: With `auto_ones_en` set and `rlos` clear, the channel sends what its QRSS and user controls select, as if the global enable were off.
- R5: With only `qrss_en` requesting a pattern, the line bit is the output of a 20-stage LFSR. The new bit is stage 20 XOR stage 17, and it is shifted in at stage 1. The output is forced to 1 when stages 1 to 14 are all zero. A 1 is sent as an AMI mark, and the LFSR advances one step per bit sent.
- R6: When several requests are active, the order of priority is: manual all ones, then automatic all ones, then QRSS, then user data.
- R7: Any test pattern sets `enc_single` and ignores `tx_neg`. With `enc_single` high, both encoder rails are never 1 together.
- R8: With no pattern requested and `single_rail` clear, `enc_pos` and `enc_neg` repeat `tx_pos` and `tx_neg` one clock later, and the polarity is held.
- R9: With no pattern requested and `single_rail` set, `tx_pos` is the data bit, and each 1 becomes a mark on the rail chosen by the shared channel polarity.
- R10: With `dig_loop` and `force_ones` both set, `lb_rx_pos` repeats `tx_pos` one clock later.
- R11: With `dig_loop` set and automatic all ones or QRSS in force, `lb_rx_pos` carries the test bit sent to the line.
- R12: Without a pattern, `lb_rx_pos` carries `tx_pos` when `dig_loop` is set and `rx_pos` otherwise, one clock later. With a pattern and `dig_loop` clear, it also carries `rx_pos`.
- R13: While QRSS is in force, the line never carries more than 14 zero bits in a row.
- R14: Each channel has its own polarity and its own LFSR, and a channel's LFSR advances only while that channel sends QRSS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| auto_ones_en | input | 1 | Global enable for all ones on receive loss of signal |
| tx_pos | input | NCH | User positive rail, or single-rail data |
| tx_neg | input | NCH | User negative rail |
| rx_pos | input | NCH | Recovered receive positive data |
| single_rail | input | NCH | User data is single-rail, encoded to AMI here |
| force_ones | input | NCH | Manual all-ones request |
| qrss_en | input | NCH | QRSS pattern request |
| rlos | input | NCH | Receive loss of signal status |
| dig_loop | input | NCH | Digital or dual loopback selected |
| enc_pos | output | NCH | Positive rail to line encoder |
| enc_neg | output | NCH | Negative rail to line encoder |
| enc_single | output | NCH | Channel is running single-rail |
| lb_rx_pos | output | NCH | Receive positive data on the loopback side |

## Verification
The assertions assume that control and data inputs change only between clock edges and stay settled across each edge. They also assume that those inputs stay at their idle value of zero until the internal reset release has completed. The bench changes every input on the falling edge only. It keeps every input at zero while reset is held and for three cycles after release, so the first cycles seen by the clocked properties are idle ones. In the sweep, each channel holds a control combination for four cycles, which lets polarity alternation and LFSR stepping run across mode changes. The data rails are still free to toggle during those four cycles.

// File: rtl/e1_diag_pkg.sv
package e1_diag_pkg;

  typedef enum logic [1:0] {
    SEL_USER = 2'd0,
    SEL_QRSS = 2'd1,
    SEL_AUTO = 2'd2,
    SEL_ONES = 2'd3
  } tx_sel_e;

  localparam int unsigned QRSS_LEN  = 20;
  localparam int unsigned QRSS_TAP  = 17;
  localparam int unsigned QRSS_ZRUN = 14;

endpackage

// File: rtl/e1_diag_prio.sv
module e1_diag_prio
  import e1_diag_pkg::*;
(
  input  logic    force_ones,
  input  logic    auto_en,
  input  logic    rlos,
  input  logic    qrss_en,
  output tx_sel_e sel
);

  always_comb begin
    if (force_ones)          sel = SEL_ONES;
    else if (auto_en && rlos) sel = SEL_AUTO;
    else if (qrss_en)        sel = SEL_QRSS;
    else                     sel = SEL_USER;
  end

endmodule

// File: rtl/e1_qrss_gen.sv
module e1_qrss_gen #(
  parameter int unsigned         W    = 20,
  parameter int unsigned         TAP  = 17,
  parameter int unsigned         ZRUN = 14,
  parameter logic [W-1:0]        SEED = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic bit_o
);

  logic [W-1:0] st_q;
  logic [W-1:0] st_d;
  logic         fb;

  always_comb begin
    fb    = st_q[W-1] ^ st_q[TAP-1];
    bit_o = fb | ~(|st_q[ZRUN-1:0]);
    st_d  = {st_q[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st_q <= SEED;
    else if (adv) st_q <= st_d;
  end

  AST_QRSS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (st_q != '0)) else $error("LFSR reached all zero"); // R5

endmodule

// File: rtl/e1_tx_chan.sv
module e1_tx_chan
  import e1_diag_pkg::*;
#(
  parameter int unsigned            QW    = QRSS_LEN,
  parameter int unsigned            QTAP  = QRSS_TAP,
  parameter int unsigned            QZRUN = QRSS_ZRUN,
  parameter logic [QRSS_LEN-1:0]    QSEED = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic tx_pos,
  input  logic tx_neg,
  input  logic rx_pos,
  input  logic single_rail,
  input  logic force_ones,
  input  logic qrss_en,
  input  logic rlos,
  input  logic dig_loop,
  output logic enc_pos,
  output logic enc_neg,
  output logic enc_sr,
  output logic lb_pos
);

  localparam int unsigned ZCW = $clog2(QZRUN + 2);

  tx_sel_e sel;
  logic    qbit;
  logic    qadv;
  logic    dbit;
  logic    diag;
  logic    sr_d, pos_d, neg_d, lb_d;
  logic    pol_q, pol_en;

  e1_diag_prio u_prio (
    .force_ones (force_ones),
    .auto_en    (auto_en),
    .rlos       (rlos),
    .qrss_en    (qrss_en),
    .sel        (sel)
  );

  e1_qrss_gen #(
    .W    (QW),
    .TAP  (QTAP),
    .ZRUN (QZRUN),
    .SEED (QSEED)
  ) u_qrss (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (qadv),
    .bit_o (qbit)
  );

  always_comb begin
    diag = (sel != SEL_USER);
    qadv = (sel == SEL_QRSS);
    sr_d = diag | single_rail;
    case (sel)
      SEL_ONES, SEL_AUTO: dbit = 1'b1;
      SEL_QRSS:           dbit = qbit;
      default:            dbit = tx_pos;
    endcase
    pos_d  = 1'b0;
    neg_d  = 1'b0;
    pol_en = 1'b0;
    if (sr_d) begin
      if (dbit) begin
        pos_d  = ~pol_q;
        neg_d  = pol_q;
        pol_en = 1'b1;
      end
    end else begin
      pos_d = tx_pos;
      neg_d = tx_neg;
    end
    if (!dig_loop)                               lb_d = rx_pos;
    else if (sel == SEL_QRSS || sel == SEL_AUTO) lb_d = dbit;
    else                                         lb_d = tx_pos;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pol_q <= 1'b0;
    else if (pol_en) pol_q <= ~pol_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_pos <= 1'b0;
      enc_neg <= 1'b0;
      enc_sr  <= 1'b0;
      lb_pos  <= 1'b0;
    end else begin
      enc_pos <= pos_d;
      enc_neg <= neg_d;
      enc_sr  <= sr_d;
      lb_pos  <= lb_d;
    end
  end

  // zero-run observer for the QRSS line stream (checking only)
  logic [ZCW-1:0] zrun_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                zrun_q <= '0;
    else if (!qadv || qbit)    zrun_q <= '0;
    else if (zrun_q != '1)     zrun_q <= zrun_q + 1'b1;
  end

  AST_ONES_ONE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    force_ones |=> (enc_sr && (enc_pos ^ enc_neg))) else $error("all ones lost a mark"); // R2
  AST_ONES_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (force_ones && enc_sr && enc_pos) |=> enc_neg) else $error("marks did not alternate"); // R2
  AST_AUTO_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_ones && auto_en && rlos) |=> (enc_sr && (enc_pos ^ enc_neg))) else $error("auto ones missing"); // R3
  AST_DIAG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (force_ones || qrss_en || (auto_en && rlos)) |=> enc_sr) else $error("diag not single rail"); // R7
  AST_SR_NO_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
    enc_sr |-> !(enc_pos && enc_neg)) else $error("double mark in single rail"); // R7
  AST_DUAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_ones && !qrss_en && !(auto_en && rlos) && !single_rail)
      |=> (enc_pos == $past(tx_pos) && enc_neg == $past(tx_neg))) else $error("dual rail not passed"); // R8
  AST_LB_TAOS: assert property (@(posedge clk) disable iff (!rst_n)
    (force_ones && dig_loop) |=> (lb_pos == $past(tx_pos))) else $error("loopback lost user data"); // R10
  AST_LB_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !dig_loop |=> (lb_pos == $past(rx_pos))) else $error("receive data not forwarded"); // R12
  AST_QRSS_ZRUN: assert property (@(posedge clk) disable iff (!rst_n)
    zrun_q <= ZCW'(QZRUN)) else $error("QRSS zero run too long"); // R13

endmodule

// File: rtl/e1_tx_diag_sel.sv
module e1_tx_diag_sel
  import e1_diag_pkg::*;
#(
  parameter int unsigned         NCH   = 8,
  parameter logic [QRSS_LEN-1:0] QSEED = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           auto_ones_en,
  input  logic [NCH-1:0] tx_pos,
  input  logic [NCH-1:0] tx_neg,
  input  logic [NCH-1:0] rx_pos,
  input  logic [NCH-1:0] single_rail,
  input  logic [NCH-1:0] force_ones,
  input  logic [NCH-1:0] qrss_en,
  input  logic [NCH-1:0] rlos,
  input  logic [NCH-1:0] dig_loop,
  output logic [NCH-1:0] enc_pos,
  output logic [NCH-1:0] enc_neg,
  output logic [NCH-1:0] enc_single,
  output logic [NCH-1:0] lb_rx_pos
);

  logic rst_s1_q, rst_s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    e1_tx_chan #(
      .QW    (QRSS_LEN),
      .QTAP  (QRSS_TAP),
      .QZRUN (QRSS_ZRUN),
      .QSEED (QSEED)
    ) u_chan (
      .clk         (clk),
      .rst_n       (rst_s2_q),
      .auto_en     (auto_ones_en),
      .tx_pos      (tx_pos[c]),
      .tx_neg      (tx_neg[c]),
      .rx_pos      (rx_pos[c]),
      .single_rail (single_rail[c]),
      .force_ones  (force_ones[c]),
      .qrss_en     (qrss_en[c]),
      .rlos        (rlos[c]),
      .dig_loop    (dig_loop[c]),
      .enc_pos     (enc_pos[c]),
      .enc_neg     (enc_neg[c]),
      .enc_sr      (enc_single[c]),
      .lb_pos      (lb_rx_pos[c])
    );
  end

endmodule

// File: tb/e1_tx_diag_sel_bench.sv
module e1_tx_diag_sel_bench;

  localparam int NCH = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n;
  logic           auto_ones_en;
  logic [NCH-1:0] tx_pos, tx_neg, rx_pos, single_rail, force_ones, qrss_en, rlos, dig_loop;
  logic [NCH-1:0] enc_pos, enc_neg, enc_single, lb_rx_pos;

  e1_tx_diag_sel #(.NCH(NCH)) u_e1_tx_diag_sel (
    .clk          (clk),
    .rst_n        (rst_n),
    .auto_ones_en (auto_ones_en),
    .tx_pos       (tx_pos),
    .tx_neg       (tx_neg),
    .rx_pos       (rx_pos),
    .single_rail  (single_rail),
    .force_ones   (force_ones),
    .qrss_en      (qrss_en),
    .rlos         (rlos),
    .dig_loop     (dig_loop),
    .enc_pos      (enc_pos),
    .enc_neg      (enc_neg),
    .enc_single   (enc_single),
    .lb_rx_pos    (lb_rx_pos)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [19:0]    m_lfsr [NCH];
  logic           m_pol  [NCH];
  logic [NCH-1:0] e_pos, e_neg, e_sr, e_lb;
  string          e_tag  [NCH];
  string          e_ltag [NCH];

  task automatic clear_inputs();
    auto_ones_en = 0;
    tx_pos = '0; tx_neg = '0; rx_pos = '0; single_rail = '0;
    force_ones = '0; qrss_en = '0; rlos = '0; dig_loop = '0;
  endtask

  // expected values from the requirements, then advance the model state
  task automatic model();
    for (int c = 0; c < NCH; c++) begin
      logic d, sr, is_auto, is_q, qb;
      int nreq;
      is_auto = !force_ones[c] && auto_ones_en && rlos[c];
      is_q    = !force_ones[c] && !is_auto && qrss_en[c];
      nreq    = int'(force_ones[c]) + int'(auto_ones_en && rlos[c]) + int'(qrss_en[c]);
      qb      = (m_lfsr[c][19] ^ m_lfsr[c][16]) | (m_lfsr[c][13:0] == 14'd0);
      if (force_ones[c] || is_auto) d = 1'b1;
      else if (is_q)                d = qb;
      else                          d = tx_pos[c];
      sr = force_ones[c] || is_auto || is_q || single_rail[c];
      if (force_ones[c])          e_tag[c] = (nreq > 1) ? "R6" : "R2";
      else if (is_auto)           e_tag[c] = (nreq > 1) ? "R6" : "R3";
      else if (is_q)              e_tag[c] = auto_ones_en ? "R4" : "R5";
      else if (auto_ones_en)      e_tag[c] = "R4";
      else                        e_tag[c] = sr ? "R9" : "R8";
      if (sr) begin
        e_pos[c] = d && !m_pol[c];
        e_neg[c] = d &&  m_pol[c];
        if (d) m_pol[c] = !m_pol[c];
      end else begin
        e_pos[c] = tx_pos[c];
        e_neg[c] = tx_neg[c];
      end
      e_sr[c] = sr;
      if (!dig_loop[c])          begin e_lb[c] = rx_pos[c]; e_ltag[c] = "R12"; end
      else if (is_auto || is_q)  begin e_lb[c] = d;         e_ltag[c] = "R11"; end
      else                       begin e_lb[c] = tx_pos[c]; e_ltag[c] = force_ones[c] ? "R10" : "R12"; end
      if (is_q) m_lfsr[c] = {m_lfsr[c][18:0], m_lfsr[c][19] ^ m_lfsr[c][16]};
    end
  endtask

  task automatic compare();
    for (int c = 0; c < NCH; c++) begin
      vectors++;
      if (enc_pos[c] !== e_pos[c] || enc_neg[c] !== e_neg[c]) begin
        miscompares++;
        $display("FAIL %s ch%0d rails actual=%b%b expected=%b%b", e_tag[c], c,
                 enc_pos[c], enc_neg[c], e_pos[c], e_neg[c]);
      end else if (enc_single[c] !== e_sr[c]) begin
        miscompares++;
        $display("FAIL R7 ch%0d single actual=%b expected=%b", c, enc_single[c], e_sr[c]);
      end else if (lb_rx_pos[c] !== e_lb[c]) begin
        miscompares++;
        $display("FAIL %s ch%0d loopback actual=%b expected=%b", e_ltag[c], c, lb_rx_pos[c], e_lb[c]);
      end
    end
  endtask

  // inputs are already driven; compute expectations, cross a rising edge, check at the falling one
  task automatic step();
    model();
    @(negedge clk);
    compare();
  endtask

  initial begin
    logic [39:0] mk0, mk1;
    int zrun, zmax;
    for (int c = 0; c < NCH; c++) begin m_lfsr[c] = 20'd1; m_pol[c] = 1'b0; end
    clear_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: outputs idle while reset is held
    vectors++;
    if ({enc_pos, enc_neg, enc_single, lb_rx_pos} !== '0) begin
      miscompares++;
      $display("FAIL R1 reset outputs actual=%h expected=0", {enc_pos, enc_neg, enc_single, lb_rx_pos});
    end
    rst_n = 1;
    repeat (3) step();

    // R14: two channels run QRSS one after the other; both start from the seed
    qrss_en[0] = 1;
    for (int i = 0; i < 40; i++) begin step(); mk0[i] = enc_pos[0] | enc_neg[0]; end
    qrss_en[0] = 0; qrss_en[1] = 1;
    for (int i = 0; i < 40; i++) begin step(); mk1[i] = enc_pos[1] | enc_neg[1]; end
    qrss_en[1] = 0;
    vectors++;
    if (mk0 !== mk1) begin
      miscompares++;
      $display("FAIL R14 ch1 pattern actual=%h expected=%h", mk1, mk0);
    end

    // R13: long QRSS run on channel 2, watch zero runs on the line
    qrss_en[2] = 1; zrun = 0; zmax = 0;
    for (int i = 0; i < 800; i++) begin
      tx_pos = NCH'($urandom); tx_neg = NCH'($urandom);
      step();
      if (enc_pos[2] | enc_neg[2]) zrun = 0; else zrun++;
      if (zrun > zmax) zmax = zrun;
    end
    vectors++;
    if (zmax > 14 || zmax == 0) begin
      miscompares++;
      $display("FAIL R13 longest zero run actual=%0d expected=1..14", zmax);
    end
    clear_inputs();

    // sweep: every channel walks all control combinations, offset per channel
    for (int v = 0; v < 4096; v++) begin
      auto_ones_en = v[8];
      for (int c = 0; c < NCH; c++) begin
        logic [4:0] m;
        m = 5'((v >> 2) + c * 13);
        force_ones[c]  = m[0];
        qrss_en[c]     = m[1];
        rlos[c]        = m[2];
        single_rail[c] = m[3];
        dig_loop[c]    = m[4];
      end
      tx_pos = NCH'($urandom); tx_neg = NCH'($urandom); rx_pos = NCH'($urandom);
      step();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog R1..R14 actual=timeout expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule